// File: doc/BRIEF.md
# Scanline and Vertical Blank Sequencer

This block follows the scanline position of the beam inside a video frame. Every horizontal-sync tick moves the line position on by one. The line count wraps at the end of the frame, and the length of the frame depends on which of two video standards is selected. When the count reaches the fixed blanking-start line, the block asserts a blanking level and fires a one-cycle interrupt pulse. At the wrap it drops the blanking level and advances a frame counter.

Two status bits are kept alongside the count:

- **Field bit.** Outside interlaced operation it is held at zero. With both interlace configuration bits set, it takes the low bit of the frame counter at each wrap.
- **Line-parity bit.** During the visible part of the frame it follows the odd/even state of the current line. It reads low for the whole of vertical blanking.

The standard select is sampled only at reset and at a frame wrap. A mid-frame change therefore never cuts a frame short.

Top module: `vline_seq`

## Requirements
- R1: While reset is held and on the first cycle after release, line_no, frame_cnt, field_bit, vblank, vblank_irq and line_parity are all 0.
- R2: Each clock with hs_tick=1 advances line_no by one. A clock with hs_tick=0 leaves every output unchanged, except that vblank_irq returns to 0.
- R3: With the standard 0 selected (std_sel=0), a frame is 263 lines. With standard 1 selected (std_sel=1), a frame is 313 lines. A tick on the last line sets line_no to 0 and increments frame_cnt in the same cycle.
- R4: vblank goes to 1 in the cycle where line_no becomes 240. It stays 1 until the tick that wraps line_no to 0, where it returns to 0.
- R5: vblank_irq is 1 for exactly one cycle, the cycle in which line_no becomes 240, and is 0 at all other times.
- R6: The standard used for the frame length is the value of std_sel captured at reset or on the wrapping tick. Changes of std_sel at any other time have no effect on the current frame.
- R7: On a wrapping tick, field_bit is set to bit 0 of the new frame_cnt when ilace_cfg equals 2'b11. For any other ilace_cfg value it is set to 0. field_bit does not change at any other time.
- R8: line_parity equals line_no[0] while line_no < 240. It is 0 while line_no >= 240.
- R9: frame_cnt counts modulo 2^FRAME_W, wrapping from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_tick | input | 1 | One-cycle horizontal-sync tick |
| std_sel | input | 1 | Video standard select: 0 = 263 lines, 1 = 313 lines |
| ilace_cfg | input | 2 | Interlace configuration bits; both set enables the field bit |
| line_no | output | LINE_W (9) | Current scanline |
| vblank | output | 1 | Vertical blanking level |
| vblank_irq | output | 1 | One-cycle vertical-blank interrupt (interrupt bit 0) |
| frame_cnt | output | FRAME_W (16) | Frame counter |
| field_bit | output | 1 | Interlace field bit (status bit 31) |
| line_parity | output | 1 | Line-parity status bit |

## Verification
The bench builds the block with the default line totals and blanking line, but with FRAME_W set to 3. Eight frames are then enough to carry frame_cnt through its wrap to zero within a short run, so the wrap case of R9 is actually reached. The run mixes both standards and switches std_sel in the middle of frames. It toggles the interlace bits between frames and inserts idle gaps between ticks, so the latched standard, the conditional field bit and the hold behaviour are all exercised.

// File: rtl/vline_pkg.sv
package vline_pkg;

    typedef enum logic {
        STD_SHORT = 1'b0,
        STD_LONG  = 1'b1
    } vstd_e;

    localparam logic [1:0] ILACE_BOTH = 2'b11;

endpackage

// File: rtl/vline_limit.sv
module vline_limit
    import vline_pkg::*;
#(
    parameter int LINES_A = 263,
    parameter int LINES_B = 313,
    parameter int LINE_W  = 9
) (
    input  vstd_e             std,
    output logic [LINE_W-1:0] last_line
);
    localparam logic [LINE_W-1:0] LAST_A = LINE_W'(LINES_A - 1);
    localparam logic [LINE_W-1:0] LAST_B = LINE_W'(LINES_B - 1);

    always_comb begin
        last_line = (std == STD_LONG) ? LAST_B : LAST_A;
    end
endmodule

// File: rtl/vline_step.sv
module vline_step #(
    parameter int LINE_W     = 9,
    parameter int BLANK_LINE = 240
) (
    input  logic              tick,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] last_line,
    output logic [LINE_W-1:0] nxt_line,
    output logic              hit_wrap,
    output logic              hit_blank
);
    localparam logic [LINE_W-1:0] PRE_BLANK = LINE_W'(BLANK_LINE - 1);

    always_comb begin
        hit_wrap  = tick && (line == last_line);
        hit_blank = tick && !hit_wrap && (line == PRE_BLANK);
        if (!tick)
            nxt_line = line;
        else if (hit_wrap)
            nxt_line = '0;
        else
            nxt_line = line + LINE_W'(1);
    end
endmodule

// File: rtl/vline_status.sv
module vline_status
    import vline_pkg::*;
#(
    parameter int LINE_W     = 9,
    parameter int BLANK_LINE = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hit_wrap,
    input  logic [LINE_W-1:0] nxt_line,
    input  logic              nxt_frame_lsb,
    input  logic [1:0]        ilace_cfg,
    output logic              field_q,
    output logic              parity_q
);
    localparam logic [LINE_W-1:0] BLANK = LINE_W'(BLANK_LINE);

    typedef struct packed {
        logic field;
        logic parity;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (tick) begin
            stat_d.parity = (nxt_line < BLANK) ? nxt_line[0] : 1'b0;
            if (hit_wrap)
                stat_d.field = (ilace_cfg == ILACE_BOTH) ? nxt_frame_lsb : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign field_q  = stat_q.field;
    assign parity_q = stat_q.parity;
endmodule

// File: rtl/vline_seq.sv
module vline_seq
    import vline_pkg::*;
#(
    parameter int LINES_A    = 263,
    parameter int LINES_B    = 313,
    parameter int BLANK_LINE = 240,
    parameter int FRAME_W    = 16,
    parameter int LINE_W     = $clog2(((LINES_A > LINES_B) ? LINES_A : LINES_B))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_tick,
    input  logic               std_sel,
    input  logic [1:0]         ilace_cfg,
    output logic [LINE_W-1:0]  line_no,
    output logic               vblank,
    output logic               vblank_irq,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               field_bit,
    output logic               line_parity
);
    typedef struct packed {
        logic [LINE_W-1:0]  line;
        logic [FRAME_W-1:0] frame;
        logic               vb;
        logic               irq;
        vstd_e              std;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic [LINE_W-1:0] last_line;
    logic [LINE_W-1:0] nxt_line;
    logic              hit_wrap;
    logic              hit_blank;

    vline_limit #(
        .LINES_A (LINES_A),
        .LINES_B (LINES_B),
        .LINE_W  (LINE_W)
    ) u_limit (
        .std       (seq_q.std),
        .last_line (last_line)
    );

    vline_step #(
        .LINE_W     (LINE_W),
        .BLANK_LINE (BLANK_LINE)
    ) u_step (
        .tick      (hs_tick),
        .line      (seq_q.line),
        .last_line (last_line),
        .nxt_line  (nxt_line),
        .hit_wrap  (hit_wrap),
        .hit_blank (hit_blank)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.line = nxt_line;
        seq_d.irq  = hit_blank;
        if (hit_blank)
            seq_d.vb = 1'b1;
        if (hit_wrap) begin
            seq_d.vb    = 1'b0;
            seq_d.frame = seq_q.frame + FRAME_W'(1);
            seq_d.std   = vstd_e'(std_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.std   <= vstd_e'(std_sel);
        end else begin
            seq_q <= seq_d;
        end
    end

    vline_status #(
        .LINE_W     (LINE_W),
        .BLANK_LINE (BLANK_LINE)
    ) u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (hs_tick),
        .hit_wrap      (hit_wrap),
        .nxt_line      (nxt_line),
        .nxt_frame_lsb (seq_d.frame[0]),
        .ilace_cfg     (ilace_cfg),
        .field_q       (field_bit),
        .parity_q      (line_parity)
    );

    assign line_no    = seq_q.line;
    assign frame_cnt  = seq_q.frame;
    assign vblank     = seq_q.vb;
    assign vblank_irq = seq_q.irq;
endmodule

// File: rtl/vline_seq_chk.sv
module vline_seq_chk #(
    parameter int LINES_A    = 263,
    parameter int LINES_B    = 313,
    parameter int BLANK_LINE = 240,
    parameter int FRAME_W    = 16,
    parameter int LINE_W     = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hs_tick,
    input logic [LINE_W-1:0]  line_no,
    input logic               vblank,
    input logic               vblank_irq,
    input logic [FRAME_W-1:0] frame_cnt,
    input logic               field_bit,
    input logic               line_parity
);
    localparam int                MAX_LINES = (LINES_A > LINES_B) ? LINES_A : LINES_B;
    localparam logic [LINE_W-1:0] MAX_LAST  = LINE_W'(MAX_LINES - 1);
    localparam logic [LINE_W-1:0] BLANK     = LINE_W'(BLANK_LINE);

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_no <= MAX_LAST); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_tick |=> $stable(line_no) && $stable(frame_cnt) && $stable(vblank)
                     && $stable(field_bit) && $stable(line_parity)); // R2

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |=> !vblank_irq); // R5

    AST_IRQ_AT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> (line_no == BLANK) && vblank); // R5

    AST_VB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> vblank_irq); // R4

    AST_VB_FALL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> (line_no == '0)); // R4

    AST_FRAME_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_cnt) |-> (line_no == '0)); // R3

    AST_PARITY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (line_no >= BLANK) |-> !line_parity); // R8

    AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_bit) |-> (line_no == '0)); // R7
endmodule

bind vline_seq vline_seq_chk #(
    .LINES_A    (LINES_A),
    .LINES_B    (LINES_B),
    .BLANK_LINE (BLANK_LINE),
    .FRAME_W    (FRAME_W),
    .LINE_W     (LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_tick     (hs_tick),
    .line_no     (line_no),
    .vblank      (vblank),
    .vblank_irq  (vblank_irq),
    .frame_cnt   (frame_cnt),
    .field_bit   (field_bit),
    .line_parity (line_parity)
);

// File: tb/sim_vline_seq.sv
module sim_vline_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LINES_A    = 263;
    localparam int LINES_B    = 313;
    localparam int BLANK_LINE = 240;
    localparam int FRAME_W    = 3;
    localparam int LINE_W     = 9;

    typedef struct {
        int line;
        int frame;
        bit vb;
        bit irq;
        bit field;
        bit par;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               hs_tick = 1'b0;
    logic               std_sel = 1'b0;
    logic [1:0]         ilace_cfg = 2'b00;
    logic [LINE_W-1:0]  line_no;
    logic               vblank;
    logic               vblank_irq;
    logic [FRAME_W-1:0] frame_cnt;
    logic               field_bit;
    logic               line_parity;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;
    exp_t q[$];

    int m_line = 0, m_frame = 0;
    bit m_vb = 0, m_irq = 0, m_field = 0, m_par = 0, m_std = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vline_seq #(
        .LINES_A    (LINES_A),
        .LINES_B    (LINES_B),
        .BLANK_LINE (BLANK_LINE),
        .FRAME_W    (FRAME_W)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_tick     (hs_tick),
        .std_sel     (std_sel),
        .ilace_cfg   (ilace_cfg),
        .line_no     (line_no),
        .vblank      (vblank),
        .vblank_irq  (vblank_irq),
        .frame_cnt   (frame_cnt),
        .field_bit   (field_bit),
        .line_parity (line_parity)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one clock, with or without a tick; model updated from requirements
    task automatic step(input bit t);
        int tot;
        exp_t e;
        hs_tick = t;
        @(posedge clk);
        tot = m_std ? LINES_B : LINES_A;
        m_irq = 0;
        if (t) begin
            if (m_line == tot - 1) begin
                m_line  = 0;
                m_frame = (m_frame + 1) % (1 << FRAME_W);
                m_vb    = 0;
                m_std   = std_sel;
                m_field = (ilace_cfg == 2'b11) ? m_frame[0] : 1'b0;
            end else begin
                m_line++;
                if (m_line == BLANK_LINE) begin
                    m_vb  = 1;
                    m_irq = 1;
                end
            end
            m_par = (m_line < BLANK_LINE) ? m_line[0] : 1'b0;
        end
        e.line = m_line; e.frame = m_frame; e.vb = m_vb;
        e.irq = m_irq; e.field = m_field; e.par = m_par;
        q.push_back(e);
        @(negedge clk);
        hs_tick = 1'b0;
    endtask

    task automatic run_ticks(input int n, input int gap_every);
        for (int i = 0; i < n; i++) begin
            step(1'b1);
            if (gap_every > 0 && (i % gap_every) == 0) step(1'b0);
        end
    endtask

    // monitor: compares design outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R2/R3/R6 line_no", int'(line_no), e.line);
                chk("R3/R9 frame_cnt", int'(frame_cnt), e.frame);
                chk("R4 vblank", int'(vblank), int'(e.vb));
                chk("R5 vblank_irq", int'(vblank_irq), int'(e.irq));
                chk("R7 field_bit", int'(field_bit), int'(e.field));
                chk("R8 line_parity", int'(line_parity), int'(e.par));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        std_sel = 1'b0;
        ilace_cfg = 2'b11;
        repeat (3) @(negedge clk);
        // R1: reset values while held
        chk("R1 line_no", int'(line_no), 0);
        chk("R1 frame_cnt", int'(frame_cnt), 0);
        chk("R1 vblank", int'(vblank), 0);
        chk("R1 vblank_irq", int'(vblank_irq), 0);
        chk("R1 field_bit", int'(field_bit), 0);
        chk("R1 line_parity", int'(line_parity), 0);
        rst_n = 1'b1;
        m_std = 1'b0;
        // R2: idle clocks hold state
        repeat (4) step(1'b0);
        // standard 0, interlaced, with gaps; switch std mid-frame (R6)
        run_ticks(100, 7);
        std_sel = 1'b1;
        run_ticks(163, 0);
        // now standard 1 frames (313 lines)
        run_ticks(313, 50);
        ilace_cfg = 2'b01;
        std_sel = 1'b0;
        run_ticks(200, 0);
        std_sel = 1'b1;          // transient change, must be ignored (R6)
        step(1'b1);
        std_sel = 1'b0;
        run_ticks(112, 0);
        ilace_cfg = 2'b11;
        // enough frames for frame_cnt to wrap (R9)
        run_ticks(263 * 6, 0);
        ilace_cfg = 2'b10;
        run_ticks(263, 0);
        repeat (3) step(1'b0);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule